// File: doc/BRIEF.md
# ADC Conversion Trigger and Scan Sequencer

This block decides, for each of four converter modules, which input channel is sampled next and when. Sixteen trigger lines, each the OR of a hardware line and a software trigger bit, are shared by all channels. Every channel selects one of these lines as a direct trigger, in edge or level mode, or takes its module's scan trigger instead. Each module's scan trigger is itself any one of the sixteen lines. When it fires, a scan cycle walks the module's scan-assigned channels that its include mask flags.

Each module has its own sequencer and converts at most one channel at a time. It offers a channel number on a req/ack handshake, waits for the converter's done pulse, then raises a one-cycle ready strobe for that channel. Module 0 serves 16 channels and modules 1 to 3 serve 7 each. The configuration slots above a module's count are unused.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset no conversion request is raised and no ready strobe is high.
- R2: A channel whose 5-bit source code is 0..15 and whose level bit is 0 latches a rising edge of that trigger line and then converts burst+1 times, where burst is its 4-bit count (0 means a single conversion). Further edges on the line are ignored until those conversions have finished.
- R3: A channel whose source code is 0..15 and whose level bit is 1 requests a conversion again and again while the line is high, and its burst count is ignored. Once the line is low, at most one more conversion follows.
- R4: A rising edge on the line picked by a module's 4-bit scan select converts, in ascending order, each channel whose source code is 16 and whose include-mask bit is 1. All other channels are skipped.
- R5: A scan edge that arrives while a scan cycle is still running is held as one pending scan, which runs right after the current one. Further edges during that time are dropped.
- R6: Pending direct-trigger channels are served before scan channels, and the lowest-numbered channel is served first within each group.
- R7: A request holds its channel number stable until ack. After ack, no new request is issued for that module until done.
- R8: One cycle after done, exactly the ready bit at index module*16+channel pulses for one cycle.
- R9: The four modules sequence independently and may have requests outstanding at the same time.
- R10: Configuration slots at or above a module's channel count (16 for module 0, 7 for the others) are never requested.
- R11: A software trigger bit acts exactly like a rising edge or high level on the hardware line with the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_hw_i | input | 16 | Hardware trigger lines |
| trig_sw_i | input | 16 | Software trigger bits, ORed with the hardware lines |
| ch_src_i | input | 320 | Per slot (module*16+channel) 5-bit source code: 0..15 direct line, 16 scan, 17..31 off |
| ch_level_i | input | 64 | Per slot level (1) or edge (0) sensitivity |
| ch_burst_i | input | 256 | Per slot 4-bit burst count |
| scan_sel_i | input | 16 | Per module 4-bit scan trigger line select |
| scan_mask_i | input | 64 | Per slot scan include mask |
| conv_req_o | output | 4 | Per module conversion request |
| conv_ch_o | output | 16 | Per module 4-bit channel number |
| conv_ack_i | input | 4 | Per module converter acknowledge |
| conv_done_i | input | 4 | Per module conversion done pulse |
| ch_rdy_o | output | 64 | Per slot result-ready strobe |

## Verification
A corrupted burst counter, scan-remaining mask or pending flag shows up at the ports as a channel converted too often, too rarely or out of order, and it appears within one request/done round trip of the fault. For that reason the bench logs every acknowledged channel number per module and compares the whole sequence against the sequence it predicts from the configuration. An error in the handshake state shows at once as a request raised during a busy conversion, or as a ready strobe on the wrong bit.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    parameter int NSRC    = 16;
    parameter int NSLOT   = 16;
    parameter int NMOD    = 4;
    parameter int BURST_W = 4;
    parameter int SEL_W   = $clog2(NSRC);
    parameter int SRC_W   = SEL_W + 1;
    parameter int CH_W    = $clog2(NSLOT);
    parameter int REM_W   = BURST_W + 1;
    parameter int SCAN_CODE = NSRC;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_BUSY = 2'd2
    } cv_state_e;
endpackage

// File: rtl/adcseq_srcedge.sv
module adcseq_srcedge
    import adcseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hw_i,
    input  logic [NSRC-1:0] sw_i,
    output logic [NSRC-1:0] lvl_o,
    output logic [NSRC-1:0] rise_o
);
    logic [NSRC-1:0] line_d, line_q;

    always_comb begin
        line_d = hw_i | sw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign lvl_o  = line_d;
    assign rise_o = line_d & ~line_q;
endmodule

// File: rtl/adcseq_pick.sv
module adcseq_pick #(
    parameter int W  = 16,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/adcseq_unit.sv
module adcseq_unit
    import adcseq_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_lvl_i,
    input  logic [NSRC-1:0]        src_rise_i,
    input  logic [NCH*SRC_W-1:0]   cfg_src_i,
    input  logic [NCH-1:0]         cfg_level_i,
    input  logic [NCH*BURST_W-1:0] cfg_burst_i,
    input  logic [SEL_W-1:0]       scan_sel_i,
    input  logic [NCH-1:0]         scan_mask_i,
    input  logic                   conv_ack_i,
    input  logic                   conv_done_i,
    output logic                   conv_req_o,
    output logic [CH_W-1:0]        conv_ch_o,
    output logic [NCH-1:0]         rdy_o
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        cv_state_e                  st;
        logic [CH_W-1:0]            ch;
        logic                       from_scan;
        logic [NCH-1:0][REM_W-1:0]  rem;
        logic [NCH-1:0]             scan_left;
        logic                       scan_pend;
        logic [NCH-1:0]             rdy;
    } unit_s;

    unit_s d, q;

    logic [NCH-1:0] edge_hit, lvl_want, scan_elig, rem_nz, dir_want;
    logic           dir_found, scan_found, scan_rise;
    logic [IW-1:0]  dir_idx, scan_idx;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [SRC_W-1:0] code;
        logic             is_dir;
        assign code        = cfg_src_i[i*SRC_W +: SRC_W];
        assign is_dir      = (code < SRC_W'(NSRC));
        assign edge_hit[i] = is_dir && !cfg_level_i[i] && src_rise_i[code[SEL_W-1:0]];
        assign lvl_want[i] = is_dir && cfg_level_i[i] && src_lvl_i[code[SEL_W-1:0]];
        assign scan_elig[i] = (code == SRC_W'(SCAN_CODE)) && scan_mask_i[i];
        assign rem_nz[i]   = (q.rem[i] != '0);
    end

    assign dir_want  = rem_nz | lvl_want;
    assign scan_rise = src_rise_i[scan_sel_i];

    adcseq_pick #(.W(NCH), .IW(IW)) u_pick_dir (
        .vec_i(dir_want), .found_o(dir_found), .idx_o(dir_idx)
    );
    adcseq_pick #(.W(NCH), .IW(IW)) u_pick_scan (
        .vec_i(q.scan_left), .found_o(scan_found), .idx_o(scan_idx)
    );

    always_comb begin
        d     = q;
        d.rdy = '0;

        // edge latch: only when the channel has nothing outstanding
        for (int i = 0; i < NCH; i++) begin
            if (edge_hit[i] && !rem_nz[i]) begin
                d.rem[i] = {1'b0, cfg_burst_i[i*BURST_W +: BURST_W]} + REM_W'(1);
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (dir_found) begin
                    d.st        = ST_REQ;
                    d.ch        = CH_W'(dir_idx);
                    d.from_scan = 1'b0;
                end else if (scan_found) begin
                    d.st        = ST_REQ;
                    d.ch        = CH_W'(scan_idx);
                    d.from_scan = 1'b1;
                end
            end
            ST_REQ: begin
                if (conv_ack_i) d.st = ST_BUSY;
            end
            ST_BUSY: begin
                if (conv_done_i) begin
                    d.st = ST_IDLE;
                    for (int i = 0; i < NCH; i++) begin
                        if (CH_W'(i) == q.ch) begin
                            d.rdy[i] = 1'b1;
                            if (q.from_scan)  d.scan_left[i] = 1'b0;
                            else if (rem_nz[i]) d.rem[i] = q.rem[i] - REM_W'(1);
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // scan trigger: start, or hold one pending restart
        if (scan_rise) begin
            if (|d.scan_left) d.scan_pend = 1'b1;
            else              d.scan_left = scan_elig;
        end
        if (!(|d.scan_left) && d.scan_pend) begin
            d.scan_left = scan_elig;
            d.scan_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign conv_req_o = (q.st == ST_REQ);
    assign conv_ch_o  = q.ch;
    assign rdy_o      = q.rdy;

    // R7: request and channel held until acknowledged
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o && !conv_ack_i |=> conv_req_o && $stable(conv_ch_o));
    // R7: nothing new while a conversion is running
    a_r7_quiet_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BUSY) && !conv_done_i |=> !conv_req_o);
    // R10: only populated channels appear on the request
    a_r10_ch_populated: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> (int'(conv_ch_o) < NCH));
    // R8: strobes are single and follow a done
    a_r8_rdy_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rdy_o));
    a_r8_rdy_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdy_o) |-> $past(conv_done_i));
    // R5: a pending scan exists only while a scan is running
    a_r5_pend_mid_scan: assert property (@(posedge clk) disable iff (!rst_n)
        q.scan_pend |-> (|q.scan_left));
    // R2: burst remainder never exceeds the largest burst
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
            q.rem[i] <= REM_W'(1 << BURST_W));
    end
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import adcseq_pkg::*;
#(
    parameter int CH_MOD0  = 16,
    parameter int CH_OTHER = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NSRC-1:0]                trig_hw_i,
    input  logic [NSRC-1:0]                trig_sw_i,
    input  logic [NMOD*NSLOT*SRC_W-1:0]    ch_src_i,
    input  logic [NMOD*NSLOT-1:0]          ch_level_i,
    input  logic [NMOD*NSLOT*BURST_W-1:0]  ch_burst_i,
    input  logic [NMOD*SEL_W-1:0]          scan_sel_i,
    input  logic [NMOD*NSLOT-1:0]          scan_mask_i,
    output logic [NMOD-1:0]                conv_req_o,
    output logic [NMOD*CH_W-1:0]           conv_ch_o,
    input  logic [NMOD-1:0]                conv_ack_i,
    input  logic [NMOD-1:0]                conv_done_i,
    output logic [NMOD*NSLOT-1:0]          ch_rdy_o
);
    logic [NSRC-1:0] src_lvl, src_rise;

    adcseq_srcedge u_edge (
        .clk(clk), .rst_n(rst_n),
        .hw_i(trig_hw_i), .sw_i(trig_sw_i),
        .lvl_o(src_lvl), .rise_o(src_rise)
    );

    for (genvar m = 0; m < NMOD; m++) begin : g_mod
        localparam int NCH  = (m == 0) ? CH_MOD0 : CH_OTHER;
        localparam int BASE = m * NSLOT;
        logic [NCH-1:0] rdy;

        adcseq_unit #(.NCH(NCH)) u_unit (
            .clk(clk), .rst_n(rst_n),
            .src_lvl_i(src_lvl), .src_rise_i(src_rise),
            .cfg_src_i(ch_src_i[BASE*SRC_W +: NCH*SRC_W]),
            .cfg_level_i(ch_level_i[BASE +: NCH]),
            .cfg_burst_i(ch_burst_i[BASE*BURST_W +: NCH*BURST_W]),
            .scan_sel_i(scan_sel_i[m*SEL_W +: SEL_W]),
            .scan_mask_i(scan_mask_i[BASE +: NCH]),
            .conv_ack_i(conv_ack_i[m]),
            .conv_done_i(conv_done_i[m]),
            .conv_req_o(conv_req_o[m]),
            .conv_ch_o(conv_ch_o[m*CH_W +: CH_W]),
            .rdy_o(rdy)
        );

        assign ch_rdy_o[BASE +: NCH] = rdy;
        if (NCH < NSLOT) begin : g_pad
            assign ch_rdy_o[BASE+NCH +: NSLOT-NCH] = '0;
        end
    end
endmodule

// File: tb/adc_trig_seq_test.sv
`timescale 1ns/1ps
module adc_trig_seq_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  hw = '0, sw = '0;
    logic [319:0] cfg_src;
    logic [63:0]  cfg_lvl, scan_mask;
    logic [255:0] cfg_burst;
    logic [15:0]  scan_sel;
    logic [3:0]   conv_req_o;
    logic [15:0]  conv_ch_o;
    logic [63:0]  ch_rdy_o;
    logic         ack_b [4];
    logic         done_b [4];
    logic [3:0]   ack_v, done_v;

    int checks = 0, fails = 0;
    int logc [4][256];
    int nlog [4];
    int expv [64];
    int nexp;
    bit multi_seen = 0;
    bit finished = 0;

    assign ack_v  = {ack_b[3], ack_b[2], ack_b[1], ack_b[0]};
    assign done_v = {done_b[3], done_b[2], done_b[1], done_b[0]};

    always #10 clk = ~clk;

    adc_trig_seq uut (
        .clk(clk), .rst_n(rst_n), .trig_hw_i(hw), .trig_sw_i(sw),
        .ch_src_i(cfg_src), .ch_level_i(cfg_lvl), .ch_burst_i(cfg_burst),
        .scan_sel_i(scan_sel), .scan_mask_i(scan_mask),
        .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
        .conv_ack_i(ack_v), .conv_done_i(done_v), .ch_rdy_o(ch_rdy_o)
    );

    always @(negedge clk) if ($countones(conv_req_o) >= 2) multi_seen = 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int nch_of(input int m);
        return (m == 0) ? 16 : 7;
    endfunction

    task automatic responder(input int m);
        int c;
        int dly;
        forever begin
            @(negedge clk);
            if (conv_req_o[m]) begin
                c = int'(conv_ch_o[m*4 +: 4]);
                dly = $urandom_range(2, 0);
                repeat (dly) @(negedge clk);
                ack_b[m] = 1'b1;
                @(negedge clk);
                ack_b[m] = 1'b0;
                if (nlog[m] < 256) logc[m][nlog[m]] = c;
                nlog[m]++;
                dly = $urandom_range(3, 1);
                repeat (dly) begin
                    check(!conv_req_o[m], "R7", "request while busy", 1, 0);
                    @(negedge clk);
                end
                done_b[m] = 1'b1;
                @(negedge clk);
                done_b[m] = 1'b0;
                check(ch_rdy_o[m*16 +: 16] == 16'(1 << c), "R8", "ready strobe",
                      int'(ch_rdy_o[m*16 +: 16]), 1 << c);
            end
        end
    endtask

    task automatic cfg_clear();
        cfg_src   = {64{5'd31}};
        cfg_lvl   = '0;
        cfg_burst = '0;
        scan_sel  = '0;
        scan_mask = '0;
    endtask

    task automatic set_ch(input int m, input int c, input int code,
                          input bit lvl, input int burst);
        cfg_src[(m*16+c)*5 +: 5]   = 5'(code);
        cfg_lvl[m*16+c]            = lvl;
        cfg_burst[(m*16+c)*4 +: 4] = 4'(burst);
    endtask

    task automatic clear_logs();
        for (int m = 0; m < 4; m++) nlog[m] = 0;
        nexp = 0;
    endtask

    task automatic push(input int v);
        expv[nexp] = v;
        nexp++;
    endtask

    task automatic pulse_hw(input int s);
        @(negedge clk) hw[s] = 1'b1;
        @(negedge clk) hw[s] = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_seq(input int m, input string tag);
        int bad;
        bad = -1;
        check(nlog[m] == nexp, tag, $sformatf("conversion count module %0d", m), nlog[m], nexp);
        if (nlog[m] == nexp) begin
            for (int i = 0; i < nexp; i++)
                if (bad < 0 && logc[m][i] != expv[i]) bad = i;
            check(bad < 0, tag, $sformatf("channel order module %0d", m),
                  (bad < 0) ? 0 : logc[m][bad], (bad < 0) ? 0 : expv[bad]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int m, s, c, b, nd;
        logic [15:0] mask;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) begin ack_b[i] = 0; done_b[i] = 0; end
        cfg_clear();
        clear_logs();
        repeat (3) @(negedge clk);
        check(conv_req_o == '0, "R1", "request in reset", int'(conv_req_o), 0);
        rst_n = 1'b1;
        drain(4);
        check(conv_req_o == '0, "R1", "request after reset", int'(conv_req_o), 0);
        check(ch_rdy_o == '0, "R1", "ready after reset", int'(ch_rdy_o != 0), 0);
        fork
            responder(0); responder(1); responder(2); responder(3);
        join_none

        // R2 + R11: software edge, burst of 3, second edge ignored
        clear_logs();
        set_ch(1, 3, 5, 0, 2);
        @(negedge clk) sw[5] = 1'b1;
        @(negedge clk) sw[5] = 1'b0;
        @(negedge clk) sw[5] = 1'b1;
        @(negedge clk) sw[5] = 1'b0;
        drain(120);
        push(3); push(3); push(3);
        check_seq(1, "R2");
        check(nlog[0] + nlog[2] + nlog[3] == 0, "R11", "other modules idle",
              nlog[0] + nlog[2] + nlog[3], 0);

        // R2: hardware edge, single conversion on module 0
        clear_logs(); cfg_clear();
        set_ch(0, 10, 9, 0, 0);
        pulse_hw(9);
        drain(80);
        push(10);
        check_seq(0, "R2");

        // R4: scan converts only scan-assigned masked channels in order
        clear_logs(); cfg_clear();
        scan_sel[2*4 +: 4] = 4'd7;
        set_ch(2, 0, 16, 0, 0); set_ch(2, 2, 16, 0, 0); set_ch(2, 5, 16, 0, 0);
        set_ch(2, 4, 16, 0, 0); set_ch(2, 6, 3, 0, 0);
        scan_mask[2*16 +: 16] = 16'b0000_0000_0110_0101;
        pulse_hw(7);
        drain(120);
        push(0); push(2); push(5);
        check_seq(2, "R4");

        // R5: retrigger mid-scan runs one more scan, extra edges dropped
        clear_logs(); cfg_clear();
        scan_sel[3*4 +: 4] = 4'd2;
        set_ch(3, 1, 16, 0, 0); set_ch(3, 3, 16, 0, 0); set_ch(3, 6, 16, 0, 0);
        scan_mask[3*16 +: 16] = 16'h004A;
        pulse_hw(2); pulse_hw(2); pulse_hw(2);
        drain(200);
        push(1); push(3); push(6); push(1); push(3); push(6);
        check_seq(3, "R5");

        // R6: direct before scan, lowest first
        clear_logs(); cfg_clear();
        scan_sel[0 +: 4] = 4'd1;
        set_ch(0, 12, 1, 0, 0); set_ch(0, 2, 1, 0, 0); set_ch(0, 9, 1, 0, 0);
        set_ch(0, 0, 16, 0, 0); set_ch(0, 1, 16, 0, 0);
        scan_mask[0 +: 16] = 16'h0003;
        pulse_hw(1);
        drain(150);
        push(2); push(9); push(12); push(0); push(1);
        check_seq(0, "R6");

        // R3: level mode repeats while high, burst ignored
        clear_logs(); cfg_clear();
        set_ch(1, 5, 11, 1, 7);
        @(negedge clk) hw[11] = 1'b1;
        for (int t = 0; t < 400 && nlog[1] < 4; t++) @(negedge clk);
        hw[11] = 1'b0;
        nd = nlog[1];
        drain(80);
        check(nd >= 4, "R3", "conversions while high", nd, 4);
        check(nlog[1] <= nd + 1, "R3", "conversions after low", nlog[1], nd + 1);
        begin
            bit ok;
            ok = 1;
            for (int i = 0; i < nlog[1] && i < 256; i++) if (logc[1][i] != 5) ok = 0;
            check(ok, "R3", "level channel number", int'(ok), 1);
        end

        // R9: all modules scan together
        clear_logs(); cfg_clear();
        for (int k = 0; k < 4; k++) begin
            scan_sel[k*4 +: 4] = 4'd14;
            set_ch(k, 0, 16, 0, 0); set_ch(k, 1, 16, 0, 0);
            scan_mask[k*16 +: 16] = 16'h0003;
        end
        multi_seen = 0;
        pulse_hw(14);
        drain(80);
        push(0); push(1);
        for (int k = 0; k < 4; k++) check_seq(k, "R9");
        check(multi_seen, "R9", "concurrent requests", int'(multi_seen), 1);

        // R10: unpopulated slots of module 1 stay silent
        clear_logs(); cfg_clear();
        scan_sel[1*4 +: 4] = 4'd0;
        set_ch(1, 1, 0, 0, 0);
        set_ch(1, 2, 16, 0, 0);
        for (int k = 7; k < 16; k++) set_ch(1, k, (k & 1) ? 0 : 16, 0, 3);
        scan_mask[1*16 +: 16] = 16'hFFFF;
        pulse_hw(0);
        drain(120);
        push(1); push(2);
        check_seq(1, "R10");

        // Random scans and bursts (R4, R2)
        for (int it = 0; it < 20; it++) begin
            clear_logs(); cfg_clear();
            m = $urandom_range(3, 0);
            s = $urandom_range(15, 0);
            mask = 16'($urandom) & ((m == 0) ? 16'hFFFF : 16'h007F);
            scan_sel[m*4 +: 4] = 4'(s);
            for (int k = 0; k < nch_of(m); k++) set_ch(m, k, 16, 0, 0);
            scan_mask[m*16 +: 16] = mask;
            pulse_hw(s);
            drain(250);
            for (int k = 0; k < 16; k++) if (mask[k]) push(k);
            check_seq(m, "R4");

            clear_logs(); cfg_clear();
            c = $urandom_range(nch_of(m) - 1, 0);
            b = $urandom_range(3, 0);
            set_ch(m, c, s, 0, b);
            pulse_hw(s);
            drain(100);
            for (int k = 0; k <= b; k++) push(c);
            check_seq(m, "R2");
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule